// File: doc/BRIEF.md
# Page Hamming ECC accumulator

This block computes a single-error-correcting Hamming code over each 256-byte chunk of a NAND page as the bytes stream past. It does not matter whether the bytes are being read from the flash or written to it. Each byte presented with `in_vld` is folded into a running parity. This happens only while `ecc_en` is high and the byte is not flagged as a spare-area byte. When the 256th accepted byte of a chunk arrives, the code for that chunk moves into a result register and the running parity restarts for the next chunk.

The result is available in two forms. `code_raw` is the 22-bit register form: six column-parity bits at the bottom and sixteen line-parity bits above them. `code_stored` is the 24-bit form written to the spare area, which is the complement of the raw value shifted left by two. A small state machine also emits the stored form as three bytes, most-significant byte first, on `emit_byte`/`emit_vld`. A clear pulse discards a partly accumulated chunk before a new transfer begins. Comparing codes and correcting data are done elsewhere.

The accumulator tracks two states. ACC_EMPTY means no byte has been taken since reset, since a clear, or since the last latch. ACC_PARTIAL means at least one byte of the current chunk has been taken. The transitions are:
- take of a non-final byte: to ACC_PARTIAL.
- take of the final byte: back to ACC_EMPTY with a latch.
- clear: to ACC_EMPTY.

The emitter has four states: EM_IDLE, EM_HI, EM_MID and EM_LO. A latch moves it from EM_IDLE to EM_HI. It then steps EM_HI to EM_MID, EM_MID to EM_LO, and EM_LO back to EM_IDLE, one state per cycle.

Top module: `hecc_page_top`

## Requirements
- R1: After reset, `code_valid` and `emit_vld` are 0 and `code_raw` is 0.
- R2: Column parity is formed for k = 0, 1 and 2, XOR-ed over all accepted bytes of a chunk. Bit 2k is the XOR of the byte bits whose bit-position index has bit k clear. Bit 2k+1 is the XOR of the byte bits whose position index has bit k set.
- R3: Line parity is formed for j = 0 to 7, where p is the XOR of all eight bits of a byte and i is the byte's index 0 to 255 within the chunk. p is added into line bit 2j when bit j of i is 0, and into line bit 2j+1 when bit j of i is 1.
- R4: The register layout of `code_raw` puts the column parity in bits [5:0] and the line parity in bits [21:6].
- R5: `code_valid` is high for exactly one cycle, in the cycle after the clock edge that accepts the 256th byte of a chunk. `code_raw` takes the new code in that same cycle and changes at no other time.
- R6: After a latch the accumulation restarts from zero at byte index 0, so each chunk's code depends only on its own bytes.
- R7: `code_stored` equals the bitwise complement of `code_raw` shifted left by two, kept to 24 bits. Its two lowest bits are therefore always 1.
- R8: `emit_vld` is high for three consecutive cycles, starting in the cycle where `code_valid` is high. `emit_byte` carries `code_stored` bits [23:16], then [15:8], then [7:0].
- R9: A byte presented while `ecc_en` is 0 is ignored: it does not change the code or the byte count.
- R10: A byte presented with `in_spare` = 1 is ignored: it does not change the code or the byte count.
- R11: `ecc_clear` resets the running parity and the byte count to zero. It wins over a byte presented in the same cycle, and it leaves `code_raw` unchanged.
- R12: Idle cycles between accepted bytes do not alter the resulting code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ecc_en | input | 1 | Accumulation enable |
| ecc_clear | input | 1 | Discard the running parity and byte count |
| in_vld | input | 1 | Byte strobe |
| in_spare | input | 1 | Byte belongs to the spare area (ignored) |
| in_byte | input | 8 | Streamed data byte |
| code_valid | output | 1 | One-cycle pulse: a chunk code was latched |
| code_raw | output | 22 | Latched code, register layout |
| code_stored | output | 24 | Latched code, spare-area layout |
| emit_vld | output | 1 | Stored-form byte on emit_byte |
| emit_byte | output | 8 | Stored-form byte, MSB first |

## Verification
Every output of the block is one register away from the edge that accepts the final byte. So `code_valid`, the new `code_raw`/`code_stored` and the first emitted byte are all due in the cycle right after that edge. The second and third emitted bytes follow one and two cycles later. The bench drives inputs on falling edges and lets a behavioural model advance on each rising edge. It compares every output against the model on the next falling edge. It also makes directed checks on that same falling edge after the last byte, and on the two falling edges after it, against hand-computed codes for single-bit chunks.

// File: rtl/hecc_pkg.sv
package hecc_pkg;
    typedef enum logic {
        ACC_EMPTY,
        ACC_PARTIAL
    } acc_state_t;

    typedef enum logic [1:0] {
        EM_IDLE,
        EM_HI,
        EM_MID,
        EM_LO
    } emit_state_t;
endpackage

// File: rtl/hecc_byte_terms.sv
module hecc_byte_terms #(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 8,
    localparam int CW    = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0]  data,
    input  logic [IDX_W-1:0]   idx,
    output logic [2*CW-1:0]    col_term,
    output logic [2*IDX_W-1:0] line_term
);
    logic byte_par;
    assign byte_par = ^data;

    for (genvar k = 0; k < CW; k++) begin : g_col
        logic ev, od;
        always_comb begin
            ev = 1'b0;
            od = 1'b0;
            for (int b = 0; b < DATA_W; b++) begin
                if (b[k]) od = od ^ data[b];
                else      ev = ev ^ data[b];
            end
        end
        assign col_term[2*k]   = ev;
        assign col_term[2*k+1] = od;
    end

    for (genvar j = 0; j < IDX_W; j++) begin : g_line
        assign line_term[2*j]   = byte_par & ~idx[j];
        assign line_term[2*j+1] = byte_par &  idx[j];
    end
endmodule

// File: rtl/hecc_accum.sv
module hecc_accum
    import hecc_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int CHUNK_BYTES = 256,
    localparam int IDX_W      = $clog2(CHUNK_BYTES),
    localparam int CW         = $clog2(DATA_W),
    localparam int RAW_W      = 2*CW + 2*IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              take,
    input  logic [DATA_W-1:0] data,
    output logic              last_take,
    output logic              valid_q,
    output logic [RAW_W-1:0]  raw_q
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CHUNK_BYTES - 1);

    acc_state_t           state_q, state_d;
    logic [IDX_W-1:0]     idx_q;
    logic [RAW_W-1:0]     acc_q, acc_next;
    logic [2*CW-1:0]      col_term;
    logic [2*IDX_W-1:0]   line_term;

    hecc_byte_terms #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_terms (
        .data      (data),
        .idx       (idx_q),
        .col_term  (col_term),
        .line_term (line_term)
    );

    assign acc_next  = acc_q ^ {line_term, col_term};
    assign last_take = take && !clear && (idx_q == LAST_IDX);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACC_EMPTY:   if (!clear && take && !last_take) state_d = ACC_PARTIAL;
            ACC_PARTIAL: if (clear || last_take)           state_d = ACC_EMPTY;
            default:     state_d = ACC_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ACC_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            idx_q   <= '0;
            raw_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (clear) begin
                acc_q <= '0;
                idx_q <= '0;
            end else if (last_take) begin
                raw_q   <= acc_next;
                acc_q   <= '0;
                idx_q   <= '0;
                valid_q <= 1'b1;
            end else if (take) begin
                acc_q <= acc_next;
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // R5: the latch pulse never lasts two cycles
    p_valid_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> !valid_q);
    // R5: the result register moves only together with the pulse
    p_raw_only_on_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(raw_q) |-> valid_q);
    // R11: clear empties the accumulator and count
    p_clear_empties_r11: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (acc_q == '0 && idx_q == '0 && state_q == ACC_EMPTY));
    // R9 / R10: no accepted byte, no change
    p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!take && !clear) |=> ($stable(acc_q) && $stable(idx_q)));
    // R6: an empty chunk starts at index zero
    p_empty_at_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ACC_EMPTY) |-> (idx_q == '0));
endmodule

// File: rtl/hecc_emitter.sv
module hecc_emitter
    import hecc_pkg::*;
#(
    parameter int STORE_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [STORE_W-1:0] stored,
    output logic               out_vld,
    output logic [7:0]         out_byte
);
    emit_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EM_IDLE: if (start) state_d = EM_HI;
            EM_HI:   state_d = EM_MID;
            EM_MID:  state_d = EM_LO;
            EM_LO:   state_d = start ? EM_HI : EM_IDLE;
            default: state_d = EM_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= EM_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        out_vld  = 1'b0;
        out_byte = 8'h00;
        unique case (state_q)
            EM_IDLE: ;
            EM_HI:  begin out_vld = 1'b1; out_byte = stored[23:16]; end
            EM_MID: begin out_vld = 1'b1; out_byte = stored[15:8];  end
            EM_LO:  begin out_vld = 1'b1; out_byte = stored[7:0];   end
            default: ;
        endcase
    end

    // R8: a latch always starts the three-byte sequence
    p_start_to_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (state_q == EM_HI));
    // R8: the sequence steps through every byte in order
    p_hi_to_mid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == EM_HI) |=> (state_q == EM_MID));
    p_mid_to_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == EM_MID) |=> (state_q == EM_LO));
endmodule

// File: rtl/hecc_page_top.sv
module hecc_page_top #(
    parameter int DATA_W      = 8,
    parameter int CHUNK_BYTES = 256,
    localparam int IDX_W      = $clog2(CHUNK_BYTES),
    localparam int CW         = $clog2(DATA_W),
    localparam int RAW_W      = 2*CW + 2*IDX_W,
    localparam int STORE_W    = RAW_W + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ecc_en,
    input  logic               ecc_clear,
    input  logic               in_vld,
    input  logic               in_spare,
    input  logic [DATA_W-1:0]  in_byte,
    output logic               code_valid,
    output logic [RAW_W-1:0]   code_raw,
    output logic [STORE_W-1:0] code_stored,
    output logic               emit_vld,
    output logic [7:0]         emit_byte
);
    logic take, last_take;

    assign take = in_vld && ecc_en && !in_spare;

    hecc_accum #(.DATA_W(DATA_W), .CHUNK_BYTES(CHUNK_BYTES)) u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (ecc_clear),
        .take      (take),
        .data      (in_byte),
        .last_take (last_take),
        .valid_q   (code_valid),
        .raw_q     (code_raw)
    );

    assign code_stored = ~{code_raw, 2'b00};

    hecc_emitter #(.STORE_W(STORE_W)) u_emit (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (last_take),
        .stored   (code_stored),
        .out_vld  (emit_vld),
        .out_byte (emit_byte)
    );

    // R8: the first emitted byte coincides with the latch pulse
    p_emit_with_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid |-> (emit_vld && emit_byte == code_stored[STORE_W-1 -: 8]));
    // R7: the two padding bits of the stored form read as ones after a latch
    p_stored_pad_r7: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid |=> (code_stored[1:0] == 2'b11));
endmodule

// File: tb/hecc_page_top_tb.sv
module hecc_page_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ecc_en = 1'b0;
    logic        ecc_clear = 1'b0;
    logic        in_vld = 1'b0;
    logic        in_spare = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        code_valid;
    logic [21:0] code_raw;
    logic [23:0] code_stored;
    logic        emit_vld;
    logic [7:0]  emit_byte;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    bit cmp_on = 1'b0;

    always #2.5 clk = ~clk;

    hecc_page_top dut_i (
        .clk(clk), .rst_n(rst_n), .ecc_en(ecc_en), .ecc_clear(ecc_clear),
        .in_vld(in_vld), .in_spare(in_spare), .in_byte(in_byte),
        .code_valid(code_valid), .code_raw(code_raw), .code_stored(code_stored),
        .emit_vld(emit_vld), .emit_byte(emit_byte)
    );

    function automatic logic [21:0] byte_code(input logic [7:0] d, input int idx);
        logic [21:0] r = '0;
        logic p = ^d;
        for (int b = 0; b < 8; b++)
            if (d[b])
                for (int k = 0; k < 3; k++)
                    if (((b >> k) & 1) == 1) r[2*k+1] = ~r[2*k+1];
                    else                     r[2*k]   = ~r[2*k];
        for (int j = 0; j < 8; j++)
            if (((idx >> j) & 1) == 1) r[6+2*j+1] = r[6+2*j+1] ^ p;
            else                       r[6+2*j]   = r[6+2*j]   ^ p;
        return r;
    endfunction

    // reference model
    logic [21:0] m_acc, m_raw;
    int          m_cnt, m_left;
    bit          m_valid;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_acc = '0; m_raw = '0; m_cnt = 0; m_left = 0; m_valid = 1'b0;
        end else begin
            m_valid = 1'b0;
            if (m_left > 0) m_left--;
            if (ecc_clear) begin
                m_acc = '0; m_cnt = 0;
            end else if (ecc_en && in_vld && !in_spare) begin
                m_acc = m_acc ^ byte_code(in_byte, m_cnt);
                if (m_cnt == 255) begin
                    m_raw = m_acc; m_acc = '0; m_cnt = 0; m_valid = 1'b1; m_left = 3;
                end else m_cnt++;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on) begin
            logic [23:0] st;
            logic [7:0]  eb;
            st = ~{m_raw, 2'b00};
            eb = (m_left > 0) ? 8'(st >> (8*(m_left-1))) : 8'h00;
            chk("R5 model code_valid", 32'(code_valid), 32'(m_valid));
            chk("R4 model code_raw", 32'(code_raw), 32'(m_raw));
            chk("R7 model code_stored", 32'(code_stored), 32'(st));
            chk("R8 model emit_vld", 32'(emit_vld), 32'(m_left > 0));
            if (m_left > 0) chk("R8 model emit_byte", 32'(emit_byte), 32'(eb));
        end
    end

    task automatic put(input logic [7:0] d, input bit en, input bit sp, input bit v, input bit clr);
        in_byte = d; ecc_en = en; in_spare = sp; in_vld = v; ecc_clear = clr;
        @(negedge clk);
    endtask

    task automatic idle();
        put(8'h00, 1'b1, 1'b0, 1'b0, 1'b0);
    endtask

    // mode 0 plain, 1 disabled bytes, 2 spare bytes, 3 idle gaps, 4 random data
    task automatic chunk(input int pos, input logic [7:0] val, input int mode);
        for (int i = 0; i < 256; i++) begin
            if (mode == 1) put(8'hFF, 1'b0, 1'b0, 1'b1, 1'b0);
            if (mode == 2) put(8'hC3, 1'b1, 1'b1, 1'b1, 1'b0);
            if (mode == 3) begin idle(); idle(); end
            if (mode == 4) put(8'($urandom), 1'b1, 1'b0, 1'b1, 1'b0);
            else           put((i == pos) ? val : 8'h00, 1'b1, 1'b0, 1'b1, 1'b0);
        end
    endtask

    task automatic expect_code(input string req, input logic [21:0] raw, input logic [23:0] st);
        chk({req, " R5 valid pulse"}, 32'(code_valid), 32'd1);
        chk({req, " R4 raw"}, 32'(code_raw), 32'(raw));
        chk({req, " R2 column"}, 32'(code_raw[5:0]), 32'(raw[5:0]));
        chk({req, " R3 line"}, 32'(code_raw[21:6]), 32'(raw[21:6]));
        chk({req, " R7 stored"}, 32'(code_stored), 32'(st));
        chk({req, " R8 hi"}, {23'd0, emit_vld, emit_byte}, {23'd0, 1'b1, st[23:16]});
        idle();
        chk({req, " R5 pulse ends"}, 32'(code_valid), 32'd0);
        chk({req, " R8 mid"}, {23'd0, emit_vld, emit_byte}, {23'd0, 1'b1, st[15:8]});
        idle();
        chk({req, " R8 lo"}, {23'd0, emit_vld, emit_byte}, {23'd0, 1'b1, st[7:0]});
        idle();
        chk({req, " R8 done"}, 32'(emit_vld), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 code_valid", 32'(code_valid), 32'd0);
        chk("R1 emit_vld", 32'(emit_vld), 32'd0);
        chk("R1 code_raw", 32'(code_raw), 32'd0);
        cmp_on = 1'b1;

        chunk(0, 8'h01, 0);
        expect_code("bit0 at index0", 22'h155555, 24'hAAAAAB);
        chunk(255, 8'h80, 0);
        expect_code("R6 bit7 at index255", 22'h2AAAAA, 24'h555557);

        chunk(0, 8'h01, 1);
        expect_code("R9 disabled bytes", 22'h155555, 24'hAAAAAB);
        chunk(0, 8'h01, 2);
        expect_code("R10 spare bytes", 22'h155555, 24'hAAAAAB);
        chunk(255, 8'h80, 3);
        expect_code("R12 idle gaps", 22'h2AAAAA, 24'h555557);

        for (int i = 0; i < 100; i++) put(8'($urandom), 1'b1, 1'b0, 1'b1, 1'b0);
        put(8'hFF, 1'b1, 1'b0, 1'b1, 1'b1);
        chk("R11 raw kept on clear", 32'(code_raw), 32'h2AAAAA);
        chunk(0, 8'h01, 0);
        expect_code("R11 after clear", 22'h155555, 24'hAAAAAB);

        for (int n = 0; n < 3; n++) begin
            chunk(0, 8'h00, 4);
            repeat (4) idle();
        end
        chunk(255, 8'h80, 0);
        expect_code("R6 after random chunks", 22'h2AAAAA, 24'h555557);

        repeat (4) idle();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R5 actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule